// File: doc/BRIEF.md
# Prescaled 8-bit Timer/Counter

This block is the 8-bit timer/counter of a small microcontroller core that runs on a four-phase clock. Each instruction cycle is four oscillator clocks, named Q1 to Q4, and the block generates this phase sequence itself. Software can write the counter and read it back through a single-strobe register port. A one-bit select on that port chooses between the counter and an 8-bit mode register.

The counter has two count sources. It can count instruction cycles, or it can count edges from an outside source. That outside source is either a pin or a comparator output, and a separate input chooses between them. The polarity of the counted edge can be selected. A power-of-two prescaler can be placed in front of the counter or bypassed.

Outside edges first pass through a metastability synchroniser. They are then sampled only on the Q2 and Q4 phases. After any write to the counter, the counter holds its new value for two instruction cycles, and the write also restarts the prescaler. When the count wraps from FFh to 00h, the block raises an overflow pulse that lasts one clock. The block has no data stream: every pin is a plain control or status level, so no handshake or back-pressure applies.

Top module: `tmr8_unit`

## Requirements
- R1: While reset is asserted, the outputs take these values: the count is 00h, the mode register reads FFh, the overflow pulse is 0 and the phase is 0 (Q1).
- R2: The phase output advances by one on every clock and wraps from 3 back to 0. One instruction cycle spans phases 0 to 3.
- R3: A counter write (`reg_wr`=1, `reg_sel`=0) loads `reg_wdata` at that clock edge. The new value is visible on `rd_data` in the next cycle. `rd_data` returns the mode register when `reg_sel`=1 and the count when `reg_sel`=0.
- R4: After a counter write, the count does not increment at the first two instruction-cycle ends that follow. With the internal source and no prescaler, the first increment occurs at the third cycle end.
- R5: The internal source with no prescaler (mode bit 5 = 0, bit 3 = 1) increments the count by one at the clock edge that ends phase 3.
- R6: The mode register fields are: bit 5 selects the outside source, bit 4 selects the falling edge, bit 3 bypasses the prescaler, and bits 2:0 hold a ratio code k. When bit 3 is 0, one count occurs every 2^(k+1) source events, from 1:2 up to 1:256.
- R7: A counter write clears the prescaler. After the write, a full 2^(k+1) source events are needed before the next count.
- R8: Mode bit 4 = 0 counts rising edges of the outside source. Mode bit 4 = 1 counts falling edges, and rising edges then have no effect.
- R9: With the outside source and no prescaler, each pulse that is at least 2 clocks high and at least 2 clocks low adds exactly one to the count. The source is sampled only on phases 1 and 3 (Q2 and Q4).
- R10: With the outside source and the prescaler enabled, the count advances once per 2^(k+1) edges of the source.
- R11: With `cmp_sel`=1 the outside source is `cmp_in`, and edges on `ext_pin` do not change the count. With `cmp_sel`=0 the outside source is `ext_pin`.
- R12: `pin_in_force` is 1 exactly when mode bit 5 is 1 and `cmp_sel` is 0.
- R13: An increment from FFh wraps the count to 00h and raises `ovf_pulse` for one clock, in the same cycle in which 00h appears. The count changes by no more than +1 per clock unless it is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock, four per instruction cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the counter, 1 selects the mode register |
| reg_wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data for the selected register |
| count_o | output | 8 | Current count |
| ext_pin | input | 1 | Outside clock pin |
| cmp_in | input | 1 | Comparator output, the alternative outside source |
| cmp_sel | input | 1 | Selects `cmp_in` as the outside source |
| pin_in_force | output | 1 | Forces the pin's direction control to input |
| ovf_pulse | output | 1 | One-clock pulse on wrap from FFh to 00h |
| phase_o | output | 2 | Current phase, 0 to 3 (Q1 to Q4) |

## Verification
The bench builds the block with its default parameters: an 8-bit count, a 3-bit ratio code, four phases, two synchroniser stages and a two-cycle hold after a write. This setting allows a run at the full 1:256 ratio within a few thousand clocks. Runs that start at FDh reach the FFh to 00h wrap. Outside pulses as short as 2 clocks high and 2 clocks low exercise the worst case of sampling on phases 1 and 3 only.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;

  localparam int CNT_W = 8;
  localparam int SEL_W = 3;
  localparam int OPT_W = 8;

  typedef struct packed {
    logic [1:0]       spare;
    logic             src_ext;
    logic             edge_fall;
    logic             pre_bypass;
    logic [SEL_W-1:0] pre_sel;
  } opt_t;

  localparam logic [OPT_W-1:0] OPT_RESET = '1;

endpackage

// File: rtl/tmr8_phase.sv
module tmr8_phase #(
  parameter int PHASES = 4,
  parameter int PH_W   = $clog2(PHASES)
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [PH_W-1:0] ph,
  output logic            ph_last,
  output logic            ph_samp
);

  localparam logic [PH_W-1:0] PH_MAX = PH_W'(PHASES - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            ph <= '0;
    else if (ph == PH_MAX) ph <= '0;
    else                   ph <= ph + 1'b1;
  end

  // end of an instruction cycle, and the odd phases (Q2, Q4) used for sampling
  assign ph_last = (ph == PH_MAX);
  assign ph_samp = ph[0];

endmodule

// File: rtl/tmr8_edge_sync.sv
module tmr8_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  input  logic invert,
  output logic lvl,
  output logic rise
);

  logic [STAGES-1:0] chain;
  logic              lvl_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
      lvl_d <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], raw ^ invert};
      lvl_d <= chain[STAGES-1];
    end
  end

  assign lvl  = chain[STAGES-1];
  assign rise = lvl & ~lvl_d;

endmodule

// File: rtl/tmr8_prescaler.sv
module tmr8_prescaler #(
  parameter int SEL_W = 3,
  parameter int DIV_W = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic [SEL_W-1:0] sel,
  output logic             carry,
  output logic             tap
);

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  for (genvar i = 0; i < DIV_W; i++) begin : g_mask
    assign mask[i] = (i <= int'(sel));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    div_q <= '0;
    else if (clr)  div_q <= '0;
    else if (step) div_q <= div_q + 1'b1;
  end

  // carry: the selected low bits are about to roll over; tap: symmetric divided level
  assign carry = step && ((div_q & mask) == mask);
  assign tap   = div_q[sel];

endmodule

// File: rtl/tmr8_unit.sv
module tmr8_unit #(
  parameter int CNT_W       = tmr8_pkg::CNT_W,
  parameter int PHASES      = 4,
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYC    = 2,
  parameter int PH_W        = $clog2(PHASES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_sel,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] rd_data,
  output logic [CNT_W-1:0] count_o,
  input  logic             ext_pin,
  input  logic             cmp_in,
  input  logic             cmp_sel,
  output logic             pin_in_force,
  output logic             ovf_pulse,
  output logic [PH_W-1:0]  phase_o
);

  import tmr8_pkg::*;

  localparam int HOLD_W = $clog2(HOLD_CYC + 1);

  opt_t              opt_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [HOLD_W-1:0] inh_q;
  logic              samp_q;
  logic              ovf_q;

  logic ph_last, ph_samp;
  logic ext_lvl, ext_rise;
  logic pre_step, pre_carry, pre_tap;
  logic ext_view, ext_ev, int_ev, cnt_ev, bump;

  wire cnt_wr = reg_wr & ~reg_sel;
  wire opt_wr = reg_wr &  reg_sel;

  tmr8_phase #(.PHASES(PHASES), .PH_W(PH_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .ph(phase_o), .ph_last(ph_last), .ph_samp(ph_samp)
  );

  tmr8_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw(cmp_sel ? cmp_in : ext_pin),
    .invert(opt_q.edge_fall), .lvl(ext_lvl), .rise(ext_rise)
  );

  assign pre_step = ~opt_q.pre_bypass & (opt_q.src_ext ? ext_rise : ph_last);

  tmr8_prescaler #(.SEL_W(SEL_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(cnt_wr), .step(pre_step),
    .sel(opt_q.pre_sel), .carry(pre_carry), .tap(pre_tap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      opt_q <= opt_t'(OPT_RESET);
    else if (opt_wr) opt_q <= opt_t'(reg_wdata[OPT_W-1:0]);
  end

  // outside path: the level (direct or divided) is looked at on Q2/Q4 only
  assign ext_view = opt_q.pre_bypass ? ext_lvl : ~pre_tap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       samp_q <= 1'b1;
    else if (cnt_wr)  samp_q <= 1'b1;
    else if (ph_samp) samp_q <= ext_view;
  end

  assign ext_ev = ph_samp & ext_view & ~samp_q;
  assign int_ev = opt_q.pre_bypass ? ph_last : pre_carry;
  assign cnt_ev = opt_q.src_ext ? ext_ev : int_ev;
  assign bump   = cnt_ev & (inh_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       inh_q <= '0;
    else if (cnt_wr)                  inh_q <= HOLD_W'(HOLD_CYC);
    else if (ph_last && inh_q != '0)  inh_q <= inh_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= ~cnt_wr & bump & (cnt_q == '1);
      if (cnt_wr)    cnt_q <= reg_wdata;
      else if (bump) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign count_o      = cnt_q;
  assign ovf_pulse    = ovf_q;
  assign rd_data      = reg_sel ? CNT_W'(opt_q) : cnt_q;
  assign pin_in_force = opt_q.src_ext & ~cmp_sel;

endmodule

// File: rtl/tmr8_checker.sv
module tmr8_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic       reg_sel,
  input logic [7:0] reg_wdata,
  input logic [7:0] count_o,
  input logic       ovf_pulse,
  input logic [1:0] phase_o,
  input logic [7:0] opt_q,
  input logic       inh_busy
);

  wire cnt_write = reg_wr & ~reg_sel;

  p_phase_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> phase_o == $past(phase_o) + 2'd1);

  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_write |=> count_o == $past(reg_wdata));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (inh_busy && !cnt_write) |=> $stable(count_o));

  p_int_q4_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!opt_q[5] && phase_o != 2'd3 && !cnt_write) |=> $stable(count_o));

  p_single_step_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_write |=> (count_o == $past(count_o) || count_o == $past(count_o) + 8'd1));

  p_ovf_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |-> count_o == 8'd0);

  p_ovf_once_r13: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |=> !ovf_pulse);

endmodule

bind tmr8_unit tmr8_checker u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata), .count_o(count_o), .ovf_pulse(ovf_pulse),
  .phase_o(phase_o), .opt_q(opt_q), .inh_busy(inh_q != '0)
);

// File: tb/sim_tmr8_unit.sv
module sim_tmr8_unit;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_sel = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] rd_data, count_o;
  logic       ext_pin = 1'b0, cmp_in = 1'b0, cmp_sel = 1'b0;
  logic       pin_in_force, ovf_pulse;
  logic [1:0] phase_o;

  int nchk = 0, nerr = 0;
  bit done = 0;

  typedef struct { logic [7:0] cnt; logic ovf; string tag; } exp_t;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr8_unit u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .rd_data(rd_data), .count_o(count_o),
    .ext_pin(ext_pin), .cmp_in(cmp_in), .cmp_sel(cmp_sel),
    .pin_in_force(pin_in_force), .ovf_pulse(ovf_pulse), .phase_o(phase_o)
  );

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: after every instruction-cycle end, compare against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (phase_o == 2'd0 && exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check8(e.tag, count_o, e.cnt);
        check8({e.tag, " ovf"}, {7'd0, ovf_pulse}, {7'd0, e.ovf});
      end
    end
  end

  task automatic opt_write(input logic [7:0] v);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0; reg_sel = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  // write lands on the clock edge that ends phase 0
  task automatic cnt_write(input logic [7:0] v);
    @(negedge clk);
    while (phase_o != 2'd0) @(negedge clk);
    reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  // driver: expected count after each of n instruction-cycle ends
  task automatic run_internal(input logic [7:0] opt, input logic [7:0] w, input int n,
                              input string tag, input bit set_opt);
    int r, pre, inh;
    logic [7:0] v;
    if (set_opt) opt_write(opt);
    cnt_write(w);
    check8("R3 readback", rd_data, w);
    r = 1 << (int'(opt[2:0]) + 1);
    pre = 0; inh = 2; v = w;
    for (int i = 0; i < n; i++) begin
      exp_t e;
      bit ev, ov;
      ev = 1'b1;
      if (!opt[3]) begin
        pre = (pre + 1) % r;
        ev = (pre == 0);
      end
      ov = 1'b0;
      if (inh == 0 && ev) begin
        ov = (v == 8'hFF);
        v = v + 8'd1;
      end
      if (inh > 0) inh--;
      e.cnt = v; e.ovf = ov; e.tag = (i < 2) ? "R4" : tag;
      exp_q.push_back(e);
    end
    wait (exp_q.size() == 0);
    @(negedge clk);
  endtask

  task automatic pulses(input bit on_cmp, input int n, input int hi, input int lo);
    for (int i = 0; i < n; i++) begin
      if (on_cmp) cmp_in = 1'b1; else ext_pin = 1'b1;
      repeat (hi) @(negedge clk);
      if (on_cmp) cmp_in = 1'b0; else ext_pin = 1'b0;
      repeat (lo) @(negedge clk);
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL R5 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [1:0] prev;
    // R1: values held during reset
    repeat (3) @(negedge clk);
    check8("R1 count", count_o, 8'h00);
    check8("R1 ovf", {7'd0, ovf_pulse}, 8'h00);
    check8("R1 phase", {6'd0, phase_o}, 8'h00);
    reg_sel = 1'b1; #1;
    check8("R1 mode", rd_data, 8'hFF);
    reg_sel = 1'b0;
    @(negedge clk); rst_n = 1'b1;

    // R12
    @(negedge clk);
    check8("R12 pin forced", {7'd0, pin_in_force}, 8'h01);
    cmp_sel = 1'b1; @(negedge clk);
    check8("R12 cmp chosen", {7'd0, pin_in_force}, 8'h00);
    cmp_sel = 1'b0;

    // R2
    prev = phase_o;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check8("R2 phase", {6'd0, phase_o}, {6'd0, prev + 2'd1});
      prev = phase_o;
    end

    // internal counting
    run_internal(8'hC8, 8'h5A, 8, "R5", 1);
    check8("R12 internal", {7'd0, pin_in_force}, 8'h00);
    reg_sel = 1'b1; #1;
    check8("R3 mode read", rd_data, 8'hC8);
    reg_sel = 1'b0;
    run_internal(8'hC8, 8'hFD, 6, "R13", 0);
    run_internal(8'hC0, 8'h33, 10, "R6", 1);
    run_internal(8'hC1, 8'h00, 6, "R6", 1);
    run_internal(8'hC1, 8'h80, 12, "R7", 0);
    run_internal(8'hC7, 8'h00, 520, "R6", 1);

    // R9: outside pin, rising edges, no prescaler
    opt_write(8'hE8);
    cnt_write(8'h20); repeat (12) @(negedge clk);
    pulses(0, 5, 2, 2); repeat (8) @(negedge clk);
    check8("R9 min pulses", count_o, 8'h25);
    pulses(0, 3, 3, 5); repeat (8) @(negedge clk);
    check8("R9 wide pulses", count_o, 8'h28);

    // R11: comparator as source, pin ignored
    cmp_sel = 1'b1;
    opt_write(8'hE8);
    cnt_write(8'h40); repeat (12) @(negedge clk);
    pulses(0, 3, 3, 3); repeat (8) @(negedge clk);
    check8("R11 pin ignored", count_o, 8'h40);
    pulses(1, 2, 3, 3); repeat (8) @(negedge clk);
    check8("R11 cmp counted", count_o, 8'h42);
    cmp_sel = 1'b0;

    // R8: falling edges
    opt_write(8'hF8);
    cnt_write(8'h10); repeat (12) @(negedge clk);
    ext_pin = 1'b1; repeat (8) @(negedge clk);
    check8("R8 rise ignored", count_o, 8'h10);
    ext_pin = 1'b0; repeat (8) @(negedge clk);
    check8("R8 fall counted", count_o, 8'h11);

    // R10: outside source through the prescaler
    opt_write(8'hE0);
    cnt_write(8'h00); repeat (12) @(negedge clk);
    pulses(0, 6, 4, 4); repeat (8) @(negedge clk);
    check8("R10 ratio 1:2", count_o, 8'h03);
    opt_write(8'hE1);
    cnt_write(8'h00); repeat (12) @(negedge clk);
    pulses(0, 8, 4, 4); repeat (8) @(negedge clk);
    check8("R10 ratio 1:4", count_o, 8'h02);

    finish_run();
  end

endmodule